// File: doc/BRIEF.md
# Register-Mapped Mailbox Pipe

This block carries single data words between a host processor and a kernel through a small set of registers on a simple memory-mapped bus. Each direction is a separate channel with a data register, a valid flag, a ready flag and a sticky status bit. The host sees the flags as software-visible registers. The kernel sees each channel as a plain valid/ready port. Every handshake step, such as qualifying a word, consuming it and acknowledging it, appears as a flag change that either side can observe. Some flags are cleared by hardware, so no software read-modify-write is needed.

In the host-to-device direction, the host loads the data register and then raises its valid flag. The block offers the word to the kernel and drops the flag as soon as the kernel accepts it. That dropped flag is the host's signal that it may load the next word. In the device-to-host direction, the kernel pushes a word. The block holds that word and raises valid until the host acknowledges it. A parameter selects whether the device-to-host channel has a ready register for backpressure. Without the ready register, reading the data register is the acknowledgement and the kernel is never held off. In both modes, a word that is overwritten before it is consumed is recorded as lost.

Top module: `mailbox_pipe`

## Requirements
- R1: Each channel decodes four word registers: data at offset 0x0, valid at 0x4, ready at 0x8 and status at 0xC. The host-to-device channel sits at base 0x00 and the device-to-host channel at base 0x10. Flag registers carry their flag in bit 0. After reset, every register reads 0 and `d2h_ready_o` is 1. `bus_rdata` carries the addressed register one cycle after `bus_read` and is 0 in every cycle that follows no read.
- R2: Writing 1 in bit 0 to the host-to-device valid register drives `h2d_valid_o` high on the next cycle, with the stored word on `h2d_data_o`. Writing 0 there has no effect.
- R3: When `h2d_valid_o` and `h2d_ready_i` are both high on a clock edge, the valid register is 0 from the next cycle on. The host can then load a new word.
- R4: A host write to the host-to-device data register while its valid flag is 1 leaves the data unchanged and sets bit 0 of the host-to-device status register. That bit stays set until the host writes 1 to it.
- R5: With the ready register enabled (`USE_READY`=1), the host-to-device ready register reads the value `h2d_ready_i` had on the previous clock edge.
- R6: A cycle with `d2h_valid_i` high stores `d2h_data_i` in the device-to-host data register, sets its valid flag and clears its ready register. With `USE_READY`=1, `d2h_ready_o` is low while that valid flag is set.
- R7: With `USE_READY`=1, a host write of 1 to the device-to-host ready register clears the valid flag and sets the ready register. The data register keeps its word.
- R8: A kernel push while the device-to-host valid flag is set, and no acknowledgement occurs in the same cycle, overwrites the word. It also sets bit 0 of the device-to-host status register, which stays set until the host writes 1 to it.
- R9: With `USE_READY`=0, the ready register reads 0 and `d2h_ready_o` stays 1. A host read of the device-to-host data register returns the word and clears the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_write | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_read | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, one cycle after the read |
| h2d_valid_o | output | 1 | Host-to-device word offered to the kernel |
| h2d_data_o | output | DATA_W | Host-to-device word |
| h2d_ready_i | input | 1 | Kernel accepts the host-to-device word |
| d2h_valid_i | input | 1 | Kernel pushes a device-to-host word |
| d2h_data_i | input | DATA_W | Device-to-host word from the kernel |
| d2h_ready_o | output | 1 | Device-to-host slot is free |

## Verification
The host-to-device path is driven in several patterns: a valid write of 0, a valid write of 1, a data write while the word is pending, and kernel acceptance followed by a fresh load. Together these separate a flag that is set only by an explicit 1 from one that follows any write, and an ignored write from a silent overwrite. The device-to-host path is tried with a push that is then acknowledged, a push onto a free slot, and a push onto a word that was never consumed. These show whether the lost bit tracks the actual overwrite or just any repeat push. A second instance without the ready register checks that a data read acts as the acknowledgement and that the kernel is never held off.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REG_LSB = 2;
  localparam int BLK_LSB = 4;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_VALID = 2'd1,
    SEL_READY = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  assign hit = (addr[ADDR_W-1:BLK_LSB] == BASE_V[ADDR_W-1:BLK_LSB]) &&
               (addr[REG_LSB-1:0] == '0);
  assign sel = reg_sel_e'(addr[BLK_LSB-1:REG_LSB]);
endmodule

// File: rtl/mbx_h2d_chan.sv
module mbx_h2d_chan #(
  parameter int DATA_W    = 32,
  parameter int USE_READY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              set_valid,
  input  logic              clr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              k_ready,
  output logic              k_valid,
  output logic [DATA_W-1:0] k_data,
  output logic              ready_q,
  output logic              err_q
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ready_q <= (USE_READY != 0) && k_ready;
      if (clr_stat) err_q <= 1'b0;
      if (wr_data) begin
        if (valid_q) err_q  <= 1'b1;
        else         data_q <= wdata;
      end
      if (set_valid)               valid_q <= 1'b1;
      else if (valid_q && k_ready) valid_q <= 1'b0;
    end
  end

  assign k_valid = valid_q;
  assign k_data  = data_q;
endmodule

// File: rtl/mbx_d2h_chan.sv
module mbx_d2h_chan #(
  parameter int DATA_W    = 32,
  parameter int USE_READY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_write,
  input  logic              ack_read,
  input  logic              clr_stat,
  input  logic              k_valid,
  input  logic [DATA_W-1:0] k_data,
  output logic              k_ready,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              ready_q,
  output logic              lost_q
);
  logic consume;

  assign consume = (USE_READY != 0) ? ack_write : ack_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ready_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      if (clr_stat) lost_q <= 1'b0;
      if (k_valid) begin
        data_q  <= k_data;
        valid_q <= 1'b1;
        ready_q <= 1'b0;
        if (valid_q && !consume) lost_q <= 1'b1;
      end else begin
        if (consume) valid_q <= 1'b0;
        if ((USE_READY != 0) && ack_write) ready_q <= 1'b1;
      end
    end
  end

  assign k_ready = (USE_READY != 0) ? !valid_q : 1'b1;
endmodule

// File: rtl/mailbox_pipe.sv
module mailbox_pipe
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int USE_READY = 1,
  parameter int H2D_BASE  = 'h00,
  parameter int D2H_BASE  = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_read,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              h2d_valid_o,
  output logic [DATA_W-1:0] h2d_data_o,
  input  logic              h2d_ready_i,
  input  logic              d2h_valid_i,
  input  logic [DATA_W-1:0] d2h_data_i,
  output logic              d2h_ready_o
);
  localparam int PAD_W = DATA_W - 1;

  logic     h_hit, d_hit;
  reg_sel_e h_sel, d_sel;

  mbx_decode #(.ADDR_W(ADDR_W), .BASE(H2D_BASE)) u_dec_h2d (
    .addr(bus_addr), .hit(h_hit), .sel(h_sel));
  mbx_decode #(.ADDR_W(ADDR_W), .BASE(D2H_BASE)) u_dec_d2h (
    .addr(bus_addr), .hit(d_hit), .sel(d_sel));

  logic h_wr_data, h_set_valid, h_clr;
  logic d_ack_wr, d_ack_rd, d_clr;

  assign h_wr_data   = bus_write && h_hit && (h_sel == SEL_DATA);
  assign h_set_valid = bus_write && h_hit && (h_sel == SEL_VALID) && bus_wdata[0];
  assign h_clr       = bus_write && h_hit && (h_sel == SEL_STAT) && bus_wdata[0];
  assign d_ack_wr    = bus_write && d_hit && (d_sel == SEL_READY) && bus_wdata[0];
  assign d_ack_rd    = bus_read  && d_hit && (d_sel == SEL_DATA);
  assign d_clr       = bus_write && d_hit && (d_sel == SEL_STAT) && bus_wdata[0];

  logic h_ready_q, h_err_q;

  mbx_h2d_chan #(.DATA_W(DATA_W), .USE_READY(USE_READY)) u_h2d (
    .clk(clk), .rst(rst),
    .wr_data(h_wr_data), .set_valid(h_set_valid), .clr_stat(h_clr),
    .wdata(bus_wdata), .k_ready(h2d_ready_i),
    .k_valid(h2d_valid_o), .k_data(h2d_data_o),
    .ready_q(h_ready_q), .err_q(h_err_q));

  logic [DATA_W-1:0] d_data_q;
  logic              d_valid_q, d_ready_q, d_lost_q;

  mbx_d2h_chan #(.DATA_W(DATA_W), .USE_READY(USE_READY)) u_d2h (
    .clk(clk), .rst(rst),
    .ack_write(d_ack_wr), .ack_read(d_ack_rd), .clr_stat(d_clr),
    .k_valid(d2h_valid_i), .k_data(d2h_data_i), .k_ready(d2h_ready_o),
    .data_q(d_data_q), .valid_q(d_valid_q), .ready_q(d_ready_q),
    .lost_q(d_lost_q));

  function automatic logic [DATA_W-1:0] flag(input logic b);
    return {{PAD_W{1'b0}}, b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !bus_read) begin
      bus_rdata <= '0;
    end else if (h_hit) begin
      case (h_sel)
        SEL_DATA:  bus_rdata <= h2d_data_o;
        SEL_VALID: bus_rdata <= flag(h2d_valid_o);
        SEL_READY: bus_rdata <= flag(h_ready_q);
        default:   bus_rdata <= flag(h_err_q);
      endcase
    end else if (d_hit) begin
      case (d_sel)
        SEL_DATA:  bus_rdata <= d_data_q;
        SEL_VALID: bus_rdata <= flag(d_valid_q);
        SEL_READY: bus_rdata <= flag(d_ready_q);
        default:   bus_rdata <= flag(d_lost_q);
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/mailbox_pipe_chk.sv
module mailbox_pipe_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int USE_READY = 1,
  parameter int H2D_BASE  = 'h00
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_read,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              h2d_valid_o,
  input logic [DATA_W-1:0] h2d_data_o,
  input logic              h2d_ready_i,
  input logic              d2h_valid_i,
  input logic              d2h_ready_o
);
  logic host_sets_valid;
  assign host_sets_valid = bus_write && bus_wdata[0] &&
                           (bus_addr == ADDR_W'(H2D_BASE + 4));

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_read |=> bus_rdata == '0);  // R1
  AST_H2D_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    h2d_valid_o && h2d_ready_i && !host_sets_valid |=> !h2d_valid_o);  // R3
  AST_H2D_HOLD: assert property (@(posedge clk) disable iff (rst)
    h2d_valid_o && !h2d_ready_i |=> h2d_valid_o && $stable(h2d_data_o));  // R4
  AST_D2H_BUSY: assert property (@(posedge clk) disable iff (rst)
    (USE_READY != 0) && d2h_valid_i |=> !d2h_ready_o);  // R6
endmodule

bind mailbox_pipe mailbox_pipe_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .USE_READY(USE_READY), .H2D_BASE(H2D_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_write(bus_write),
  .bus_wdata(bus_wdata), .bus_read(bus_read), .bus_rdata(bus_rdata),
  .h2d_valid_o(h2d_valid_o), .h2d_data_o(h2d_data_o),
  .h2d_ready_i(h2d_ready_i), .d2h_valid_i(d2h_valid_i),
  .d2h_ready_o(d2h_ready_o)
);

// File: tb/mailbox_pipe_test.sv
`timescale 1ns/1ps
module mailbox_pipe_test;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_write = 1'b0, bus_read = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] rdata, nr_rdata;
  logic          h2d_valid, nr_h2d_valid;
  logic [DW-1:0] h2d_data, nr_h2d_data;
  logic          h2d_ready = 1'b0;
  logic          d2h_valid = 1'b0, nr_d2h_valid = 1'b0;
  logic [DW-1:0] d2h_data = '0, nr_d2h_data = '0;
  logic          d2h_ready, nr_d2h_ready;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mailbox_pipe #(.DATA_W(DW), .ADDR_W(AW), .USE_READY(1)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_read(bus_read), .bus_rdata(rdata),
    .h2d_valid_o(h2d_valid), .h2d_data_o(h2d_data), .h2d_ready_i(h2d_ready),
    .d2h_valid_i(d2h_valid), .d2h_data_i(d2h_data), .d2h_ready_o(d2h_ready));

  mailbox_pipe #(.DATA_W(DW), .ADDR_W(AW), .USE_READY(0)) uut_nr (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_read(bus_read), .bus_rdata(nr_rdata),
    .h2d_valid_o(nr_h2d_valid), .h2d_data_o(nr_h2d_data), .h2d_ready_i(1'b0),
    .d2h_valid_i(nr_d2h_valid), .d2h_data_i(nr_d2h_data),
    .d2h_ready_o(nr_d2h_ready));

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_write = 1'b1;
    @(negedge clk);
    bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d,
                        output logic [DW-1:0] dn);
    @(negedge clk);
    bus_addr = a; bus_read = 1'b1;
    @(negedge clk);
    bus_read = 1'b0;
    d = rdata;
    dn = nr_rdata;
  endtask

  task automatic push(input logic nr, input logic [DW-1:0] d);
    @(negedge clk);
    if (nr) begin nr_d2h_valid = 1'b1; nr_d2h_data = d; end
    else    begin d2h_valid = 1'b1;    d2h_data = d;    end
    @(negedge clk);
    d2h_valid = 1'b0; nr_d2h_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v, vn;
    for (int i = 0; i < 8; i++) begin
      bus_rd(AW'(i * 4), v, vn);
      check($sformatf("R1 reset reg 0x%0h", i * 4), v, '0);
    end
    check("R1 d2h_ready_o after reset", {31'b0, d2h_ready}, 1);
    check("R1 h2d_valid_o after reset", {31'b0, h2d_valid}, 0);
    @(negedge clk);
    check("R1 rdata idle", rdata, '0);
  endtask

  task automatic t_h2d;
    logic [DW-1:0] v, vn;
    bus_wr(8'h00, 32'hA5A5_0001);
    bus_wr(8'h04, 32'h0);
    check("R2 valid write of 0", {31'b0, h2d_valid}, 0);
    bus_wr(8'h04, 32'h1);
    check("R2 valid set", {31'b0, h2d_valid}, 1);
    check("R2 data offered", h2d_data, 32'hA5A5_0001);
    bus_rd(8'h04, v, vn);
    check("R2 valid reg reads 1", v, 1);
    bus_wr(8'h00, 32'h0000_2222);
    check("R4 data kept while pending", h2d_data, 32'hA5A5_0001);
    bus_rd(8'h0C, v, vn);
    check("R4 error bit set", v, 1);
    bus_wr(8'h0C, 32'h1);
    bus_rd(8'h0C, v, vn);
    check("R4 error bit cleared", v, 0);
    @(negedge clk);
    h2d_ready = 1'b1;
    @(negedge clk);
    check("R3 valid auto-cleared", {31'b0, h2d_valid}, 0);
    bus_rd(8'h08, v, vn);
    check("R5 ready reg follows kernel", v, 1);
    h2d_ready = 1'b0;
    @(negedge clk);
    bus_rd(8'h08, v, vn);
    check("R5 ready reg drops", v, 0);
    bus_rd(8'h04, v, vn);
    check("R3 valid reg reads 0", v, 0);
    bus_wr(8'h00, 32'h0000_3333);
    bus_wr(8'h04, 32'h1);
    check("R3 new word accepted", h2d_data, 32'h0000_3333);
  endtask

  task automatic t_d2h;
    logic [DW-1:0] v, vn;
    push(1'b0, 32'h0000_1111);
    check("R6 d2h_ready_o low while held", {31'b0, d2h_ready}, 0);
    bus_rd(8'h10, v, vn);
    check("R6 data captured", v, 32'h0000_1111);
    bus_rd(8'h14, v, vn);
    check("R6 valid reg set", v, 1);
    bus_wr(8'h18, 32'h1);
    bus_rd(8'h14, v, vn);
    check("R7 valid cleared by ack", v, 0);
    bus_rd(8'h18, v, vn);
    check("R7 ready reg set by ack", v, 1);
    bus_rd(8'h10, v, vn);
    check("R7 data retained", v, 32'h0000_1111);
    check("R7 d2h_ready_o high", {31'b0, d2h_ready}, 1);
    push(1'b0, 32'h0000_2222);
    bus_rd(8'h18, v, vn);
    check("R6 ready reg cleared by push", v, 0);
    bus_rd(8'h1C, v, vn);
    check("R8 no loss on free slot", v, 0);
    push(1'b0, 32'h0000_3333);
    bus_rd(8'h1C, v, vn);
    check("R8 lost bit set", v, 1);
    bus_rd(8'h10, v, vn);
    check("R8 word overwritten", v, 32'h0000_3333);
    bus_wr(8'h1C, 32'h1);
    bus_rd(8'h1C, v, vn);
    check("R8 lost bit cleared", v, 0);
  endtask

  task automatic t_noready;
    logic [DW-1:0] v, vn;
    push(1'b1, 32'h0000_4444);
    check("R9 d2h_ready_o stays 1", {31'b0, nr_d2h_ready}, 1);
    bus_rd(8'h14, v, vn);
    check("R9 valid set", vn, 1);
    bus_rd(8'h10, v, vn);
    check("R9 read returns word", vn, 32'h0000_4444);
    bus_rd(8'h14, v, vn);
    check("R9 read consumed word", vn, 0);
    bus_wr(8'h18, 32'h1);
    bus_rd(8'h18, v, vn);
    check("R9 ready reg reads 0", vn, 0);
    push(1'b1, 32'h0000_5555);
    push(1'b1, 32'h0000_6666);
    bus_rd(8'h1C, v, vn);
    check("R9 R8 overwrite recorded", vn, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_h2d();
    t_d2h();
    t_noready();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule